// File: doc/BRIEF.md
# Acquisition frame status sequencer

This block paces a data-acquisition run. A start request loads how many frames the run should return. After that, each rising edge of the sync data-valid input produces one frame, presented as a 32-bit status word on a valid/ready output. The sequencer keeps track of how many frames remain. It sets the last-frame flag on the frame that ends the run, whatever the reason the run ends.

A run can end in three ways. The count can run out. A stop command can arrive, in which case the next triggered frame is the final one. A data-timing error can be raised, in which case a final frame flagged with the error goes out at once, without waiting for a trigger. In every case exactly one frame carries the terminating flags. The frame counter is then cleared, so that sync pulses arriving later produce nothing until a new start request loads a count.

Top module: `frame_run_seq`

## Requirements
- R1: A synchronous active-high `rst` leaves the block idle: `frm_valid` is low and the remaining-frame count is zero, so sync pulses arriving after reset without a start request produce no frame.
- R2: A start request with count N > 0, followed by N triggers, yields exactly N frames. Frames 1 to N-1 have status 0x00000200. Frame N has status 0x00000201 (last-frame set).
- R3: A stop request while a run is armed makes the next triggered frame carry status bits 0 (last-frame) and 1 (stop), which is 0x00000203. Only that one frame carries the stop flag.
- R4: A timing error while a run is armed emits a final frame in the next cycle, without a trigger. It has bit 0 and bit 2 (timing error) set, bit 9 equal to `sync_dv` in the cycle the error was sampled, and bit 1 set only if a stop was pending. The frame counter is cleared.
- R5: Once the final frame of a run has been accepted, further sync pulses produce no frame until a new start request.
- R6: Status word layout: bit 0 is last-frame, bit 1 is stop, bit 2 is timing error, bit 9 is the level of `sync_dv`. All other bits are zero.
- R7: A stop request or timing error while idle produces no frame and has no effect on the next run.
- R8: While `frm_valid` is high and `frm_ready` is low, the frame and its status word hold steady. Triggers during that time are dropped and not counted. A stop request during that time applies to the next frame.
- R9: A start request while a run is active is ignored and does not reload the count. A start request with a count of zero is ignored.
- R10: A frame is produced only on a rising edge of `sync_dv`. A level held high for many cycles yields one frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Start request, one cycle |
| start_count | input | CNT_W | Number of frames for the run |
| stop_req | input | 1 | Stop command, one cycle |
| timing_err | input | 1 | Data-timing error indication |
| sync_dv | input | 1 | Sync data-valid trigger level |
| frm_valid | output | 1 | Frame status word is valid |
| frm_ready | input | 1 | Consumer accepts the frame |
| frm_status | output | 32 | Frame status word |

## Verification
The bench targets the terminating cases. After a stop it checks that exactly one flagged frame appears. A design that flags the final frame but leaves the counter armed would send a second flagged frame, or resume sending on the next sync pulse. After a timing error it checks that the error frame comes out without a trigger and that later pulses are silent. A design that only sets the flag and leaves the counter running would keep returning frames. It also holds a frame under back-pressure while triggers and a stop arrive, and drives a sync level that stays high for many cycles. A design that counts dropped triggers, loses the pending stop, or triggers on the level rather than the edge would return the wrong number of frames or the wrong flags.

// File: rtl/frs_pkg.sv
package frs_pkg;
    localparam int STAT_W   = 32;
    localparam int BIT_LAST = 0;
    localparam int BIT_STOP = 1;
    localparam int BIT_TERR = 2;
    localparam int BIT_DV   = 9;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ARMED = 2'd1,
        S_SEND  = 2'd2
    } frs_state_e;
endpackage

// File: rtl/frs_edge_det.sv
module frs_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic rise_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = level_i;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= prev_d;
    end

    assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/frs_frame_cnt.sv
module frs_frame_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    input  logic             clr_i,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] remain_d, remain_q;

    always_comb begin
        remain_d = remain_q;
        if (clr_i)       remain_d = '0;
        else if (load_i) remain_d = load_val_i;
        else if (dec_i)  remain_d = remain_q - ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) remain_q <= '0;
        else     remain_q <= remain_d;
    end

    assign last_o = (remain_q == ONE);

    // R2: a frame is never counted once the run is exhausted
    a_r2_no_underflow: assert property (@(posedge clk) disable iff (rst)
        dec_i |-> remain_q != '0);
endmodule

// File: rtl/frs_status_pack.sv
module frs_status_pack
    import frs_pkg::*;
(
    input  logic              last_i,
    input  logic              stop_i,
    input  logic              terr_i,
    input  logic              dv_i,
    output logic [STAT_W-1:0] word_o
);
    always_comb begin
        for (int b = 0; b < STAT_W; b++) begin
            case (b)
                BIT_LAST: word_o[b] = last_i;
                BIT_STOP: word_o[b] = stop_i;
                BIT_TERR: word_o[b] = terr_i;
                BIT_DV:   word_o[b] = dv_i;
                default:  word_o[b] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/frame_run_seq.sv
module frame_run_seq
    import frs_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_valid,
    input  logic [CNT_W-1:0]  start_count,
    input  logic              stop_req,
    input  logic              timing_err,
    input  logic              sync_dv,
    output logic              frm_valid,
    input  logic              frm_ready,
    output logic [STAT_W-1:0] frm_status
);
    typedef struct packed {
        frs_state_e        st;
        logic              stop_pend;
        logic              terr_pend;
        logic              last;
        logic [STAT_W-1:0] word;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              dv_rise;
    logic              cnt_last;
    logic              cnt_load, cnt_dec, cnt_clr;
    logic              terr_now, stop_now;
    logic              pk_last;
    logic [STAT_W-1:0] pk_word;

    frs_edge_det u_edge (
        .clk     (clk),
        .rst     (rst),
        .level_i (sync_dv),
        .rise_o  (dv_rise)
    );

    frs_frame_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load_i     (cnt_load),
        .load_val_i (start_count),
        .dec_i      (cnt_dec),
        .clr_i      (cnt_clr),
        .last_o     (cnt_last)
    );

    assign terr_now = timing_err | ctl_q.terr_pend;
    assign stop_now = stop_req   | ctl_q.stop_pend;
    assign pk_last  = terr_now | stop_now | cnt_last;

    frs_status_pack u_pack (
        .last_i (pk_last),
        .stop_i (stop_now),
        .terr_i (terr_now),
        .dv_i   (sync_dv),
        .word_o (pk_word)
    );

    always_comb begin
        ctl_d    = ctl_q;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        cnt_clr  = 1'b0;
        case (ctl_q.st)
            S_IDLE: begin
                ctl_d.stop_pend = 1'b0;
                ctl_d.terr_pend = 1'b0;
                if (start_valid && start_count != '0) begin
                    cnt_load = 1'b1;
                    ctl_d.st = S_ARMED;
                end
            end
            S_ARMED: begin
                if (terr_now) begin
                    cnt_clr         = 1'b1;
                    ctl_d.word      = pk_word;
                    ctl_d.last      = 1'b1;
                    ctl_d.stop_pend = 1'b0;
                    ctl_d.terr_pend = 1'b0;
                    ctl_d.st        = S_SEND;
                end else if (dv_rise) begin
                    if (stop_now) cnt_clr = 1'b1;
                    else          cnt_dec = 1'b1;
                    ctl_d.word      = pk_word;
                    ctl_d.last      = pk_last;
                    ctl_d.stop_pend = 1'b0;
                    ctl_d.st        = S_SEND;
                end else if (stop_req) begin
                    ctl_d.stop_pend = 1'b1;
                end
            end
            S_SEND: begin
                if (!ctl_q.last) begin
                    if (stop_req)   ctl_d.stop_pend = 1'b1;
                    if (timing_err) ctl_d.terr_pend = 1'b1;
                end
                if (frm_ready) ctl_d.st = ctl_q.last ? S_IDLE : S_ARMED;
            end
            default: ctl_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    assign frm_valid  = (ctl_q.st == S_SEND);
    assign frm_status = ctl_q.word;

    // R8: a stalled frame keeps its word
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && !frm_ready) |=> (frm_valid && $stable(frm_status)));

    // R5: nothing follows an accepted final frame
    a_r5_quiet_after_last: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && frm_ready && frm_status[BIT_LAST]) |=> !frm_valid);

    // R3: a stop flag always comes with the last-frame flag
    a_r3_stop_is_last: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && frm_status[BIT_STOP]) |-> frm_status[BIT_LAST]);

    // R4: a timing error while armed gives an error frame next cycle
    a_r4_terr_immediate: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.st == S_ARMED && timing_err) |=>
            (frm_valid && frm_status[BIT_TERR] && frm_status[BIT_LAST]));

    // R6: only the defined bits may be set
    a_r6_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        frm_valid |-> (frm_status & ~32'h0000_0207) == '0);
endmodule

// File: tb/tb_frame_run_seq.sv
`timescale 1ns/1ps
module tb_frame_run_seq;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_valid = 1'b0;
    logic [CNT_W-1:0] start_count = '0;
    logic             stop_req = 1'b0;
    logic             timing_err = 1'b0;
    logic             sync_dv = 1'b0;
    logic             frm_valid;
    logic             frm_ready = 1'b1;
    logic [31:0]      frm_status;

    int total = 0;
    int bad = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    frame_run_seq #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .start_valid(start_valid), .start_count(start_count),
        .stop_req(stop_req), .timing_err(timing_err), .sync_dv(sync_dv),
        .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_status(frm_status)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // monitor: a handshake happens at the next edge when both are high
    always @(negedge clk) begin
        #1;
        if (!rst && frm_valid && frm_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected frame", frm_status, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(frm_status == e, t, frm_status, e);
            end
        end
    end

    task automatic expect_frame(input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic start_run(input int n);
        @(negedge clk);
        start_valid = 1'b1;
        start_count = CNT_W'(n);
        @(negedge clk);
        start_valid = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop_req = 1'b1;
        @(negedge clk); stop_req = 1'b0;
    endtask

    task automatic pulse_terr(input bit dv, input bit push, input logic [31:0] e,
                              input string t);
        @(negedge clk);
        timing_err = 1'b1;
        sync_dv = dv;
        if (push) expect_frame(e, t);
        @(negedge clk);
        timing_err = 1'b0;
        sync_dv = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic trig(input bit push, input logic [31:0] e, input string t);
        @(negedge clk);
        sync_dv = 1'b1;
        if (push) expect_frame(e, t);
        @(negedge clk);
        sync_dv = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_quiet(input string t);
        repeat (2) @(negedge clk);
        #1;
        chk(!frm_valid && exp_q.size() == 0, t, 32'(frm_valid), 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(frm_valid == 1'b0, "R1 reset valid low", 32'(frm_valid), 32'h0);
        trig(1'b0, 0, "");
        expect_quiet("R1 no frame without start");

        // R2 normal run
        start_run(3);
        trig(1'b1, 32'h200, "R2 frame 1");
        trig(1'b1, 32'h200, "R2 frame 2");
        trig(1'b1, 32'h201, "R2 frame 3 last");
        trig(1'b0, 0, "");
        trig(1'b0, 0, "");
        expect_quiet("R5 after normal end");

        // R3 stop mid-run
        start_run(5);
        trig(1'b1, 32'h200, "R3 frame before stop");
        pulse_stop();
        trig(1'b1, 32'h203, "R3 stop frame");
        trig(1'b0, 0, "");
        trig(1'b0, 0, "");
        expect_quiet("R3 single stop frame R5");

        // R4 timing error, dv low
        start_run(4);
        trig(1'b1, 32'h200, "R4 frame before error");
        pulse_terr(1'b0, 1'b1, 32'h005, "R4 error frame dv low R6");
        trig(1'b0, 0, "");
        expect_quiet("R4 counter cleared R5");

        // R4 timing error, dv high
        start_run(4);
        pulse_terr(1'b1, 1'b1, 32'h205, "R4 error frame dv high R6");
        trig(1'b0, 0, "");
        expect_quiet("R4 silent after error");

        // R7 stop / error while idle
        pulse_stop();
        pulse_terr(1'b0, 1'b0, 0, "");
        trig(1'b0, 0, "");
        expect_quiet("R7 idle commands no frame");
        start_run(2);
        trig(1'b1, 32'h200, "R7 clean run frame 1");
        trig(1'b1, 32'h201, "R7 clean run frame 2");
        expect_quiet("R7 run ends normally");

        // R8 back-pressure
        @(negedge clk); frm_ready = 1'b0;
        start_run(3);
        trig(1'b1, 32'h200, "R8 held frame");
        #1;
        chk(frm_valid && frm_status == 32'h200, "R8 held before",
            frm_status, 32'h200);
        trig(1'b0, 0, "");
        pulse_stop();
        #1;
        chk(frm_valid && frm_status == 32'h200, "R8 held stable",
            frm_status, 32'h200);
        @(negedge clk); frm_ready = 1'b1;
        repeat (2) @(negedge clk);
        trig(1'b1, 32'h203, "R8 stop applied after stall");
        trig(1'b0, 0, "");
        expect_quiet("R8 dropped trigger not counted");

        // R9 start while armed, zero count
        start_run(2);
        trig(1'b1, 32'h200, "R9 frame 1");
        start_run(9);
        trig(1'b1, 32'h201, "R9 restart ignored, last");
        trig(1'b0, 0, "");
        expect_quiet("R9 no reload");
        start_run(0);
        trig(1'b0, 0, "");
        expect_quiet("R9 zero count ignored");

        // R10 long high level
        start_run(2);
        @(negedge clk);
        sync_dv = 1'b1;
        expect_frame(32'h200, "R10 level frame");
        repeat (6) @(negedge clk);
        sync_dv = 1'b0;
        expect_quiet("R10 one frame per edge");
        trig(1'b1, 32'h201, "R10 second edge last");
        expect_quiet("R10 run done");

        chk(exp_q.size() == 0, "R2 all expected frames seen",
            32'(exp_q.size()), 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule